// File: doc/BRIEF.md
# Frame Buffer Rectangle Fill Engine

This block paints a solid rectangle into a 1024 x 512 halfword frame buffer. A caller hands it a fill command as three 32-bit words at once: a 24-bit colour, the top-left corner and the width/height. The block then streams one pixel write per accepted handshake on a valid/ready write port. Each write carries a 10-bit column, a 9-bit row and a 16-bit pixel value.

Work along a row is done in tiles of 16 pixels. The start column is rounded down to a tile boundary and the width is rounded up to whole tiles, so every written row covers complete tiles. The 24-bit colour is reduced to 15-bit RGB with bit 15 held at zero. The block has no mask inputs: every pixel in the rectangle is written with the same value. `busy` is high while pixels remain to be written, and `done` pulses for one cycle when a fill ends.

Write port back-pressure: when `wr_valid` is high and `wr_ready` is low, `wr_x`, `wr_y` and `wr_data` hold their values until the write is taken. A write completes on a rising edge where both `wr_valid` and `wr_ready` are high. Commands use the same rule on `cmd_valid`/`cmd_ready`, and `cmd_ready` is low while `busy` is high.

Top module: `fill_engine`

## Requirements
- R1: Each written pixel is {0, B[7:3], G[7:3], R[7:3]}. R is colour bits 7..0, G is bits 15..8 and B is bits 23..16. The packed pixel holds red in bits 4..0, green in bits 9..5 and blue in bits 14..10.
- R2: Bit 15 of every written pixel is 0, and no pixel of the rounded rectangle is skipped.
- R3: The corner word gives X in bits 15..0 and Y in bits 31..16. The first write is at column (X mod 1024) rounded down to a multiple of 16, and at row Y mod 512.
- R4: The size word gives width W in bits 15..0 and height H in bits 31..16. Each row holds W rounded up to a multiple of 16 pixels, and there are H rows.
- R5: Writes go in row-major order, one pixel per accepted handshake. The column steps by 1 modulo 1024 within a row, and the row steps by 1 modulo 512 between rows.
- R6: While `wr_valid` is high and `wr_ready` is low, the write address and data stay stable and `wr_valid` stays high.
- R7: If W or H is zero, the command produces no writes and `done` pulses in the cycle after acceptance.
- R8: While `busy` is high, `cmd_ready` is low and an offered command has no effect on the fill in progress.
- R9: `busy` rises in the cycle after a non-empty command is accepted. In the cycle after the last write is accepted, `busy` is low and `done` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Fill command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_color | input | 24 | Colour, R in 7..0, G in 15..8, B in 23..16 |
| cmd_corner | input | 32 | Top-left, X in 15..0, Y in 31..16 |
| cmd_size | input | 32 | Width in 15..0, height in 31..16 |
| wr_valid | output | 1 | Pixel write request |
| wr_ready | input | 1 | Frame buffer takes the write |
| wr_x | output | 10 | Write column |
| wr_y | output | 9 | Write row |
| wr_data | output | 16 | 15-bit RGB pixel, bit 15 zero |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle end-of-fill pulse |

## Verification
The bound checker checks several rules on every cycle:
- bit 15 of the written data stays clear;
- address and data hold under back-pressure;
- the column steps by one inside a tile row;
- every row begins on a tile boundary;
- a fill cannot be interrupted;
- `done` is a one-cycle pulse with `busy` low.

The checker cannot check the exact colour packing, the corner and size rounding, the pixel count, wraparound at both edges of the buffer, empty commands, or refusal of a command offered mid-fill. The bench scenarios show these by comparing every write against a model of the rectangle under random back-pressure.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int WORD_W  = 32;
  localparam int COLOR_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_state_e;
endpackage

// File: rtl/fill_color_pack.sv
module fill_color_pack #(
  parameter int CH_IN  = 8,
  parameter int CH_OUT = 5,
  parameter int NCH    = 3,
  localparam int IN_W  = CH_IN * NCH,
  localparam int OUT_W = CH_OUT * NCH + 1
) (
  input  logic [IN_W-1:0]  color_in,
  output logic [OUT_W-1:0] pixel_out
);
  localparam int DROP = CH_IN - CH_OUT;

  logic [CH_OUT*NCH-1:0] packed_ch;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [CH_IN-1:0] chan;
    assign chan = color_in[c*CH_IN +: CH_IN];
    assign packed_ch[c*CH_OUT +: CH_OUT] = CH_OUT'(chan >> DROP);
  end

  assign pixel_out = {1'b0, packed_ch};
endmodule

// File: rtl/fill_geom.sv
module fill_geom #(
  parameter int TILE_LG = 4,
  parameter int LEN_W   = 16,
  localparam int TILE   = 1 << TILE_LG
) (
  input  logic [2*LEN_W-1:0] corner,
  input  logic [2*LEN_W-1:0] size,
  output logic [LEN_W-1:0]   x0,
  output logic [LEN_W-1:0]   y0,
  output logic [LEN_W:0]     cols,
  output logic [LEN_W-1:0]   rows,
  output logic               empty
);
  localparam logic [LEN_W-1:0] XMASK = ~LEN_W'(TILE - 1);
  localparam logic [LEN_W:0]   CMASK = ~(LEN_W+1)'(TILE - 1);

  logic [LEN_W-1:0] width;

  assign width = size[LEN_W-1:0];
  assign rows  = size[2*LEN_W-1:LEN_W];
  assign x0    = corner[LEN_W-1:0] & XMASK;
  assign y0    = corner[2*LEN_W-1:LEN_W];
  assign cols  = ({1'b0, width} + (LEN_W+1)'(TILE - 1)) & CMASK;
  assign empty = (width == '0) || (rows == '0);
endmodule

// File: rtl/fill_walker.sv
module fill_walker #(
  parameter int XW    = 10,
  parameter int YW    = 9,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] x0,
  input  logic [LEN_W-1:0] y0,
  input  logic [LEN_W:0]   cols,
  input  logic [LEN_W-1:0] rows,
  input  logic             step,
  output logic [XW-1:0]    pos_x,
  output logic [YW-1:0]    pos_y,
  output logic             last
);
  logic [LEN_W-1:0] base_x, base_y;
  logic [LEN_W:0]   col, col_end;
  logic [LEN_W-1:0] row, row_end;
  logic             row_done;

  assign row_done = (col == col_end);
  assign last     = row_done && (row == row_end);
  assign pos_x    = XW'(base_x + col[LEN_W-1:0]);
  assign pos_y    = YW'(base_y + row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_x  <= '0;
      base_y  <= '0;
      col     <= '0;
      row     <= '0;
      col_end <= '0;
      row_end <= '0;
    end else if (start) begin
      base_x  <= x0;
      base_y  <= y0;
      col     <= '0;
      row     <= '0;
      col_end <= cols - 1'b1;
      row_end <= rows - 1'b1;
    end else if (step) begin
      if (row_done) begin
        col <= '0;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
  parameter int XW      = 10,
  parameter int YW      = 9,
  parameter int TILE_LG = 4,
  parameter int CH_IN   = 8,
  parameter int CH_OUT  = 5,
  localparam int LEN_W  = fill_pkg::WORD_W / 2,
  localparam int PIX_W  = 3 * CH_OUT + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [3*CH_IN-1:0]    cmd_color,
  input  logic [2*LEN_W-1:0]    cmd_corner,
  input  logic [2*LEN_W-1:0]    cmd_size,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [XW-1:0]         wr_x,
  output logic [YW-1:0]         wr_y,
  output logic [PIX_W-1:0]      wr_data,
  output logic                  busy,
  output logic                  done
);
  import fill_pkg::*;

  fill_state_e state_q, state_d;
  logic [PIX_W-1:0] pixel_c, pixel_q;
  logic [LEN_W-1:0] g_x0, g_y0, g_rows;
  logic [LEN_W:0]   g_cols;
  logic             g_empty;
  logic             cmd_fire, wr_fire, last_px;

  assign busy      = (state_q == ST_FILL);
  assign done      = (state_q == ST_DONE);
  assign cmd_ready = !busy;
  assign wr_valid  = busy;
  assign wr_data   = pixel_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign wr_fire   = wr_valid && wr_ready;

  fill_color_pack #(.CH_IN(CH_IN), .CH_OUT(CH_OUT), .NCH(3)) u_pack (
    .color_in (cmd_color),
    .pixel_out(pixel_c)
  );

  fill_geom #(.TILE_LG(TILE_LG), .LEN_W(LEN_W)) u_geom (
    .corner(cmd_corner),
    .size  (cmd_size),
    .x0    (g_x0),
    .y0    (g_y0),
    .cols  (g_cols),
    .rows  (g_rows),
    .empty (g_empty)
  );

  fill_walker #(.XW(XW), .YW(YW), .LEN_W(LEN_W)) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cmd_fire),
    .x0   (g_x0),
    .y0   (g_y0),
    .cols (g_cols),
    .rows (g_rows),
    .step (wr_fire),
    .pos_x(wr_x),
    .pos_y(wr_y),
    .last (last_px)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FILL: if (wr_fire && last_px) state_d = ST_DONE;
      default: begin
        if (cmd_fire) state_d = g_empty ? ST_DONE : ST_FILL;
        else          state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pixel_q <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_fire) pixel_q <= pixel_c;
    end
  end
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int XW      = 10,
  parameter int YW      = 9,
  parameter int TILE_LG = 4,
  parameter int PIX_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [XW-1:0]    wr_x,
  input logic [YW-1:0]    wr_y,
  input logic [PIX_W-1:0] wr_data,
  input logic             busy,
  input logic             done
);
  assert_top_bit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wr_data[PIX_W-1]);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_x) && $stable(wr_y) && $stable(wr_data));

  assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && (wr_x[TILE_LG-1:0] != '1)
      |=> wr_valid && (wr_x == $past(wr_x) + 1'b1) && $stable(wr_y));

  assert_tile_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (wr_x[TILE_LG-1:0] == '0));

  assert_no_interrupt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(wr_valid && wr_ready) |=> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(cmd_valid && cmd_ready) |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_valid);
endmodule

bind fill_engine fill_engine_chk #(
  .XW(XW), .YW(YW), .TILE_LG(TILE_LG), .PIX_W(PIX_W)
) u_fill_engine_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_x     (wr_x),
  .wr_y     (wr_y),
  .wr_data  (wr_data),
  .busy     (busy),
  .done     (done)
);

// File: tb/fill_engine_bench.sv
module fill_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [23:0] cmd_color = '0;
  logic [31:0] cmd_corner = '0;
  logic [31:0] cmd_size = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [9:0]  wr_x;
  logic [8:0]  wr_y;
  logic [15:0] wr_data;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  fill_engine u_fill_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_color(cmd_color), .cmd_corner(cmd_corner), .cmd_size(cmd_size),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_x(wr_x), .wr_y(wr_y),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  // {back-pressure, colour, corner, size}
  localparam int NV = 6;
  localparam logic [88:0] VEC [NV] = '{
    {1'b0, 24'h723F00, 32'h0000_0000, 32'h0002_0014},
    {1'b1, 24'h00C3F3, 32'h0005_0025, 32'h0003_0010},
    {1'b1, 24'hFFFFFF, 32'h01FE_03FA, 32'h0003_0014},
    {1'b1, 24'h123456, 32'h0203_0412, 32'h0001_0001},
    {1'b0, 24'hABCDEF, 32'h0010_0020, 32'h0004_0000},
    {1'b1, 24'h0F0F0F, 32'h0010_0020, 32'h0000_0008}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_pix(input logic [23:0] c);
    return {1'b0, c[23:19], c[15:11], c[7:3]};
  endfunction

  // Runs one fill; if intrude, offers a second command while busy.
  task automatic run_fill(input logic [23:0] col, input logic [31:0] cor,
                          input logic [31:0] sz, input bit bp, input bit intrude);
    int w16 = ((int'(sz[15:0]) + 15) / 16) * 16;
    int h   = int'(sz[31:16]);
    int total = w16 * h;
    int got = 0;
    bit expect_done = 1'b0;
    bit ended = 1'b0;
    @(negedge clk);
    cmd_color = col; cmd_corner = cor; cmd_size = sz; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (total == 0) begin
      check(done && !wr_valid && !busy, "R7", {done, wr_valid, busy}, 3'b100);
      @(negedge clk);
      check(!done && !wr_valid, "R7", {done, wr_valid}, 0);
      return;
    end
    check(busy && wr_valid, "R9", {busy, wr_valid}, 2'b11);
    if (intrude) begin
      cmd_color = 24'h0; cmd_corner = 32'h0; cmd_size = 32'h0001_0001; cmd_valid = 1'b1;
    end
    for (int cyc = 0; cyc < 4000 && !ended; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (intrude && cyc == 3) begin
        check(!cmd_ready, "R8", cmd_ready, 0);
        cmd_valid = 1'b0;
      end
      if (expect_done) begin
        check(done && !busy, "R9", {done, busy}, 2'b10);
        ended = 1'b1;
      end else if (done) begin
        check(0, "R4", got, total);
        ended = 1'b1;
      end else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready = bp ? lfsr[0] : 1'b1;
        if (wr_valid && wr_ready) begin
          int r = got / w16;
          int cx = got % w16;
          int ex = (int'(cor[15:0] & 16'hFFF0) + cx) % 1024;
          int ey = (int'(cor[31:16]) + r) % 512;
          check(int'(wr_x) == ex, "R3/R5 x", wr_x, ex);
          check(int'(wr_y) == ey, "R3/R5 y", wr_y, ey);
          check(wr_data == model_pix(col), "R1/R2 data", wr_data, model_pix(col));
          got++;
          if (got == total) expect_done = 1'b1;
        end
      end
    end
    wr_ready = 1'b0;
    check(ended && got == total, "R4 count", got, total);
    @(negedge clk);
    check(!done && !wr_valid, "R8 idle after", {done, wr_valid}, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !wr_valid && cmd_ready, "R9 reset",
          {busy, done, wr_valid, cmd_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run_fill(VEC[i][87:64], VEC[i][63:32], VEC[i][31:0], VEC[i][88], 1'b0);
    end
    // R8: command offered mid-fill is refused and does not alter the fill
    run_fill(24'h8040F8, 32'h0020_0043, 32'h0002_0021, 1'b1, 1'b1);
    // R6: long stall keeps write stable
    @(negedge clk);
    cmd_color = 24'h00FF00; cmd_corner = 32'h0007_0009; cmd_size = 32'h0001_0010; cmd_valid = 1'b1;
    wr_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(wr_valid && wr_x == 10'd0 && wr_y == 9'd7, "R6 stall", {wr_x, wr_y}, {10'd0, 9'd7});
    check(wr_data == 16'h03E0, "R1 green", wr_data, 16'h03E0);
    wr_ready = 1'b1;
    repeat (16) @(negedge clk);
    check(done && !busy, "R9 end", {done, busy}, 2'b10);
    wr_ready = 1'b0;
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule